// File: doc/BRIEF.md
# Event Flag and Interrupt Controller

This block collects events from a set of input channels and from one port-level detect signal, keeps each of them as a sticky flag, and turns the flags into one or more level-sensitive interrupt lines. Every interrupt line owns an independent enable mask. Software changes a mask through a write-one-to-set register and a write-one-to-clear register. Both registers read back the whole mask.

A channel event arrives as a single-cycle pulse. The port event is taken from the rising edge of a level detect input. Software reads the flag register and writes it directly. Each bit takes the written value, so writing 0 acknowledges an event. When a hardware event and a software clear of the same flag fall in the same cycle, the event wins. Every event also drives a one-cycle publish pulse toward an event-routing fabric, provided that event's bit is set in a publish enable register.

Flags and enable masks share one bit layout. Bits 0 to N_CH-1 are the channel events, bit 31 is the port event, and the bits between them are unused.

Top module: `evt_irq_ctrl`

## Requirements
- R1: A one-cycle pulse on ch_evt_i[i] sets bit i of the flag register (address 0), visible from the cycle after the pulse.
- R2: Bit 31 of the flag register is set only when detect_i goes from low to high; detect_i held high or falling to low sets nothing.
- R3: A write to the set-enable register of line k (address 2+2k) ORs the written bits into that line's mask, and reading it returns the whole mask.
- R4: A write to the clear-enable register of line k (address 3+2k) clears the written 1 bits from that line's mask; reading it also returns the whole mask, and a line whose only enabled pending flag is disabled goes low.
- R5: irq_o[k] is high, as a level, for as long as some flag bit is set and its bit in mask k is set, and low otherwise.
- R6: A write to address 0 gives each valid flag bit the written value, so writing 0 clears it; the interrupt lines follow in the same cycle the flags change.
- R7: Each interrupt line is evaluated only against its own mask, so enabling an event on one line never raises another.
- R8: An event whose bit is set in the publish enable register (address 1, same bit layout) gives a pulse on pub_ch_o[i] or pub_port_o in the cycle after the event, lasting exactly one cycle; with the bit clear no pulse appears.
- R9: If a channel pulse and a software write of 0 hit the same flag in the same cycle, the flag ends up set.
- R10: Bits 30 down to N_CH of the flag, mask and publish registers always read 0 and ignore writes.
- R11: After reset all flags, masks and publish enables are 0, every irq_o is low and no publish pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_evt_i | input | N_CH | Single-cycle event pulses, one per channel |
| detect_i | input | 1 | Port detect level; its rising edge is the port event |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for bus_addr_i, combinational |
| irq_o | output | N_IRQ | Level interrupt lines |
| pub_ch_o | output | N_CH | One-cycle publish pulses for channel events |
| pub_port_o | output | 1 | One-cycle publish pulse for the port event |

## Verification
On every cycle the assertions check several relations. A channel pulse always leaves its flag set, and a set-enable or clear-enable write always moves the named mask bit. A low detect input never raises the port flag, and an event always beats a simultaneous software clear. With no writes and no events the interrupt lines stay stable. A publish pulse appears only after a matching event. The bench scenarios show what needs a chosen history: the exact read-back values of masks and reserved bits, that line 1 stays low while only line 0 is enabled, that a publish pulse lasts exactly one cycle and is absent when disabled, and that a held-high detect input does not re-raise a cleared flag.

// File: rtl/eic_pkg.sv
package eic_pkg;

   localparam int unsigned REG_W    = 32;
   localparam int unsigned PORT_BIT = REG_W - 1;

   typedef logic [REG_W-1:0] word_t;

   // Bits that exist for a given channel count: channels plus the port bit.
   function automatic word_t valid_bits(input int unsigned n_ch);
      word_t m;
      m = '0;
      for (int unsigned b = 0; b < REG_W; b++) begin
         if (b < n_ch || b == PORT_BIT) m[b] = 1'b1;
      end
      return m;
   endfunction

   // Word address map: 0 flags, 1 publish enables, then set/clear pairs.
   function automatic int unsigned addr_set(input int unsigned line);
      return 2 + 2 * line;
   endfunction

   function automatic int unsigned addr_clr(input int unsigned line);
      return 3 + 2 * line;
   endfunction

endpackage

// File: rtl/eic_flags.sv
module eic_flags
   import eic_pkg::*;
#(
   parameter int unsigned N_CH = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] ch_evt_i,
   input  logic            detect_i,
   input  logic            sw_we_i,
   input  word_t           sw_data_i,
   output word_t           hit_o,
   output word_t           flags_o
);

   localparam word_t VALID = valid_bits(N_CH);

   logic  det_q;
   logic  det_rise;
   word_t hit;
   word_t flag_q;
   word_t flag_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) det_q <= 1'b0;
      else        det_q <= detect_i;
   end

   assign det_rise = detect_i & ~det_q;

   always_comb begin
      hit                = '0;
      hit[N_CH-1:0]      = ch_evt_i;
      hit[PORT_BIT]      = det_rise;
   end

   // Software write replaces the flags; hardware events are ORed on top.
   always_comb begin
      flag_d = sw_we_i ? (sw_data_i & VALID) : flag_q;
      flag_d = flag_d | hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= flag_d;
   end

   assign hit_o   = hit;
   assign flags_o = flag_q;

endmodule

// File: rtl/eic_line.sv
module eic_line
   import eic_pkg::*;
#(
   parameter int unsigned N_CH     = 8,
   parameter bit          LINE_REG = 1'b0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  set_we_i,
   input  logic  clr_we_i,
   input  word_t wdata_i,
   input  word_t flags_i,
   output word_t mask_o,
   output logic  irq_o
);

   localparam word_t VALID = valid_bits(N_CH);

   word_t mask_q;
   word_t mask_d;
   logic  irq_raw;

   always_comb begin
      mask_d = mask_q;
      if (set_we_i) mask_d = mask_d | (wdata_i & VALID);
      if (clr_we_i) mask_d = mask_d & ~wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_d;
   end

   assign irq_raw = |(flags_i & mask_q);
   assign mask_o  = mask_q;

   generate
      if (LINE_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_raw;
         end
         assign irq_o = irq_q;
      end else begin : g_comb
         assign irq_o = irq_raw;
      end
   endgenerate

endmodule

// File: rtl/eic_publish.sv
module eic_publish
   import eic_pkg::*;
#(
   parameter int unsigned N_CH = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en_we_i,
   input  word_t           wdata_i,
   input  word_t           hit_i,
   output word_t           en_o,
   output logic [N_CH-1:0] pub_ch_o,
   output logic            pub_port_o
);

   localparam word_t VALID = valid_bits(N_CH);

   word_t en_q;
   word_t pub_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q <= '0;
      else if (en_we_i) en_q <= wdata_i & VALID;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pub_q <= '0;
      else        pub_q <= hit_i & en_q;
   end

   assign en_o       = en_q;
   assign pub_ch_o   = pub_q[N_CH-1:0];
   assign pub_port_o = pub_q[PORT_BIT];

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
   import eic_pkg::*;
#(
   parameter int unsigned N_CH     = 8,
   parameter int unsigned N_IRQ    = 2,
   parameter int unsigned ADDR_W   = 3,
   parameter bit          LINE_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_CH-1:0]   ch_evt_i,
   input  logic              detect_i,
   input  logic              bus_we_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   output logic [N_IRQ-1:0]  irq_o,
   output logic [N_CH-1:0]   pub_ch_o,
   output logic              pub_port_o
);

   localparam int unsigned N_REGS = 2 + 2 * N_IRQ;

   generate
      if (N_CH < 1 || N_CH > REG_W - 1) begin : g_bad_nch
         $error("evt_irq_ctrl: N_CH must lie in 1..%0d", REG_W - 1);
      end
      if (N_IRQ < 1) begin : g_bad_nirq
         $error("evt_irq_ctrl: N_IRQ must be at least 1");
      end
      if ((1 << ADDR_W) < N_REGS) begin : g_bad_aw
         $error("evt_irq_ctrl: ADDR_W too narrow for %0d registers", N_REGS);
      end
   endgenerate

   localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_PUBEN = ADDR_W'(1);

   word_t                       flag_vec;
   word_t                       hit_vec;
   word_t                       pub_en;
   logic [N_IRQ-1:0][REG_W-1:0] en_mask;

   eic_flags #(.N_CH(N_CH)) i_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .ch_evt_i  (ch_evt_i),
      .detect_i  (detect_i),
      .sw_we_i   (bus_we_i && bus_addr_i == A_FLAGS),
      .sw_data_i (bus_wdata_i),
      .hit_o     (hit_vec),
      .flags_o   (flag_vec)
   );

   eic_publish #(.N_CH(N_CH)) i_publish (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_we_i    (bus_we_i && bus_addr_i == A_PUBEN),
      .wdata_i    (bus_wdata_i),
      .hit_i      (hit_vec),
      .en_o       (pub_en),
      .pub_ch_o   (pub_ch_o),
      .pub_port_o (pub_port_o)
   );

   generate
      for (genvar k = 0; k < N_IRQ; k++) begin : g_line
         localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(addr_set(k));
         localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(addr_clr(k));
         eic_line #(.N_CH(N_CH), .LINE_REG(LINE_REG)) i_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_we_i (bus_we_i && bus_addr_i == A_SET),
            .clr_we_i (bus_we_i && bus_addr_i == A_CLR),
            .wdata_i  (bus_wdata_i),
            .flags_i  (flag_vec),
            .mask_o   (en_mask[k]),
            .irq_o    (irq_o[k])
         );
      end
   endgenerate

   // Read mux: set and clear addresses of a line both return its mask.
   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i == A_FLAGS) bus_rdata_o = flag_vec;
      if (bus_addr_i == A_PUBEN) bus_rdata_o = pub_en;
      for (int unsigned k = 0; k < N_IRQ; k++) begin
         if (bus_addr_i == ADDR_W'(addr_set(k)) || bus_addr_i == ADDR_W'(addr_clr(k)))
            bus_rdata_o = en_mask[k];
      end
   end

endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk
   import eic_pkg::*;
#(
   parameter int unsigned N_CH     = 8,
   parameter int unsigned N_IRQ    = 2,
   parameter int unsigned ADDR_W   = 3,
   parameter bit          LINE_REG = 1'b0
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [N_CH-1:0]             ch_evt_i,
   input logic                        detect_i,
   input logic                        bus_we_i,
   input logic [ADDR_W-1:0]           bus_addr_i,
   input logic [31:0]                 bus_wdata_i,
   input logic [N_IRQ-1:0]            irq_o,
   input logic [N_CH-1:0]             pub_ch_o,
   input logic                        pub_port_o,
   input logic [REG_W-1:0]            flag_vec,
   input logic [N_IRQ-1:0][REG_W-1:0] en_mask
);

   logic flag_wr;
   assign flag_wr = bus_we_i && bus_addr_i == '0;

   assert_flag_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ch_evt_i[0] |=> flag_vec[0]);

   assert_no_port_without_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_vec[PORT_BIT] && !detect_i && !flag_wr) |=> !flag_vec[PORT_BIT]);

   assert_set_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we_i && bus_addr_i == ADDR_W'(addr_set(0)) && bus_wdata_i[0]) |=> en_mask[0][0]);

   assert_clear_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we_i && bus_addr_i == ADDR_W'(addr_clr(0)) && bus_wdata_i[0]) |=> !en_mask[0][0]);

   generate
      if (!LINE_REG) begin : g_level
         assert_irq_level_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!bus_we_i && ch_evt_i == '0 && !detect_i) |=> $stable(irq_o));
      end
   endgenerate

   assert_publish_after_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pub_ch_o[0] |-> $past(ch_evt_i[0]));

   assert_port_publish_after_detect_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pub_port_o |-> $past(detect_i));

   assert_event_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && !bus_wdata_i[0] && ch_evt_i[0]) |=> flag_vec[0]);

endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(
   .N_CH(N_CH), .N_IRQ(N_IRQ), .ADDR_W(ADDR_W), .LINE_REG(LINE_REG)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ch_evt_i    (ch_evt_i),
   .detect_i    (detect_i),
   .bus_we_i    (bus_we_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .irq_o       (irq_o),
   .pub_ch_o    (pub_ch_o),
   .pub_port_o  (pub_port_o),
   .flag_vec    (flag_vec),
   .en_mask     (en_mask)
);

// File: tb/test_evt_irq_ctrl.sv
module test_evt_irq_ctrl;

   localparam int N_CH   = 8;
   localparam int N_IRQ  = 2;
   localparam int ADDR_W = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [N_CH-1:0]   ch_evt = '0;
   logic              detect = 1'b0;
   logic              we = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [31:0]       wdata = '0;
   logic [31:0]       rdata;
   logic [N_IRQ-1:0]  irq;
   logic [N_CH-1:0]   pub_ch;
   logic              pub_port;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   evt_irq_ctrl #(.N_CH(N_CH), .N_IRQ(N_IRQ), .ADDR_W(ADDR_W)) i_evt_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .ch_evt_i(ch_evt), .detect_i(detect),
      .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .irq_o(irq), .pub_ch_o(pub_ch), .pub_port_o(pub_port)
   );

   typedef struct packed {
      logic        is_wr;
      logic [2:0]  a;
      logic [31:0] d;     // write data, or expected read data
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [0:NV-1] = '{
      '{1'b0, 3'd0, 32'h0000_0000, 8'd11},   // R11 flags clear
      '{1'b0, 3'd2, 32'h0000_0000, 8'd11},   // R11 mask 0 clear
      '{1'b1, 3'd2, 32'h0000_0005, 8'd3},
      '{1'b1, 3'd2, 32'h0000_0010, 8'd3},
      '{1'b0, 3'd2, 32'h0000_0015, 8'd3},    // R3 bits accumulate
      '{1'b0, 3'd3, 32'h0000_0015, 8'd4},    // R4 clear address reads mask
      '{1'b1, 3'd3, 32'h0000_0004, 8'd4},
      '{1'b0, 3'd2, 32'h0000_0011, 8'd4},    // R4 only bit 2 removed
      '{1'b1, 3'd2, 32'hFFFF_FFFF, 8'd10},
      '{1'b0, 3'd2, 32'h8000_00FF, 8'd10},   // R10 reserved bits stay 0
      '{1'b1, 3'd3, 32'hFFFF_FFFF, 8'd4},
      '{1'b0, 3'd4, 32'h0000_0000, 8'd7},    // R7 line 1 untouched
      '{1'b1, 3'd1, 32'h8000_0003, 8'd8},
      '{1'b0, 3'd1, 32'h8000_0003, 8'd8},    // R8 publish enables
      '{1'b1, 3'd0, 32'hFFFF_FFFF, 8'd6},
      '{1'b0, 3'd0, 32'h8000_00FF, 8'd6},    // R6 / R10 flags written
      '{1'b1, 3'd0, 32'h0000_0000, 8'd6},
      '{1'b0, 3'd0, 32'h0000_0000, 8'd6}     // R6 write 0 clears
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic pulse_ch(input logic [N_CH-1:0] v);
      @(negedge clk);
      ch_evt = v;
      @(negedge clk);
      ch_evt = '0;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state at the outputs
      check("R11 irq", 32'(irq), 32'h0);
      check("R11 pub", {23'd0, pub_port, pub_ch}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].is_wr) begin
            bus_write(VECS[i].a, VECS[i].d);
         end else begin
            bus_read(VECS[i].a, r);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), r, VECS[i].d);
         end
      end

      // R1 / R7 / R8: channel 2 event with line 0 enabled, publish disabled
      bus_write(3'd2, 32'h4);
      pulse_ch(8'h04);
      bus_read(3'd0, r);
      check("R1 flag", r, 32'h4);
      check("R7 lines", 32'(irq), 32'h1);
      check("R8 disabled publish", 32'(pub_ch), 32'h0);
      repeat (3) @(negedge clk);
      check("R5 level held", 32'(irq), 32'h1);
      bus_write(3'd0, 32'h0);
      check("R6 irq after clear", 32'(irq), 32'h0);

      // R8: channel 1 publish enabled, exactly one cycle
      pulse_ch(8'h02);
      check("R8 publish", 32'(pub_ch), 32'h2);
      check("R5 masked flag", 32'(irq), 32'h0);
      @(negedge clk);
      check("R8 one cycle", 32'(pub_ch), 32'h0);
      bus_write(3'd0, 32'h0);

      // R2: port detect edges
      @(negedge clk); detect = 1'b1;
      @(negedge clk);
      bus_read(3'd0, r);
      check("R2 rise sets", r, 32'h8000_0000);
      check("R8 port publish", 32'(pub_port), 32'h1);
      @(negedge clk);
      check("R8 port one cycle", 32'(pub_port), 32'h0);
      bus_write(3'd0, 32'h0);
      repeat (2) @(negedge clk);
      bus_read(3'd0, r);
      check("R2 held high", r, 32'h0);
      detect = 1'b0;
      @(negedge clk);
      bus_read(3'd0, r);
      check("R2 fall ignored", r, 32'h0);

      // R7 / R4: port event on line 1 only, then disable it
      bus_write(3'd4, 32'h8000_0000);
      @(negedge clk); detect = 1'b1;
      @(negedge clk);
      check("R7 line 1 only", 32'(irq), 32'h2);
      bus_write(3'd5, 32'h8000_0000);
      check("R4 irq drops", 32'(irq), 32'h0);
      bus_read(3'd0, r);
      check("R4 flag kept", r, 32'h8000_0000);
      detect = 1'b0;

      // R9: event and software clear together
      @(negedge clk);
      we = 1'b1; addr = 3'd0; wdata = 32'h0; ch_evt = 8'h08;
      @(negedge clk);
      we = 1'b0; ch_evt = '0;
      bus_read(3'd0, r);
      check("R9 set wins", r, 32'h8);

      @(negedge clk);
      finish_run();
   end

endmodule